// File: doc/BRIEF.md
# Scatter Segment to DMA Descriptor Splitter

This block turns a stream of scatter segments into a stream of bus-master DMA descriptors. Each segment is a 32-bit start address and a 32-bit byte length, offered on a valid/ready port. A sideband bit marks the segment that closes the request. Each segment is cut into chunks, and no chunk runs across a 64 KB address boundary. Each chunk leaves as one descriptor: an address word plus a count word. The descriptors go out on a second valid/ready port, in order.

Some controllers read a 16-bit byte count of zero as "nothing" where it should mean 64 KB. In the normal encoding, any chunk that would be a full 64 KB is therefore cut into two 32 KB descriptors. The final descriptor of a request carries an end-of-table mark. A second encoding is selected by `quad_mode`. It stores the count in units of 32-bit words in the upper half of the count word, never splits a full 64 KB chunk, and never sets an end mark. A request may need more descriptors than the table can hold (`MAX_DESC`). In that case generation stops and the rest of the request is swallowed. A single-cycle done pulse then reports overflow, so the caller can fall back to programmed transfers. A request that carries no bytes reports empty.

The unit keeps one descriptor in a holding register before passing it to the output. This lets it mark the final descriptor correctly even when trailing segments of the request have zero length.

Top module: `span_splitter`

## Requirements
- R1: Every chunk length is the smaller of the bytes left in the segment and 0x10000 minus address bits 15:0. The next chunk starts at the previous address plus the previous length, so no descriptor crosses a 64 KB boundary.
- R2: When `quad_mode`=0, a chunk that would be exactly 0x10000 bytes is emitted as two descriptors of 0x8000 bytes. The first is at the chunk address and the second is at that address plus 0x8000.
- R3: When `quad_mode`=0, the count word holds the byte count in bits 15:0 and zero in bits 30:16. Bit 31 is 1 on the final descriptor of a request that did not overflow, and 0 on every other descriptor.
- R4: When `quad_mode`=1, the count word holds (bytes/4)-1 in bits 31:16 and zero in bits 15:0. No end mark is added, and a 0x10000-byte chunk is a single descriptor with field value 0x3FFF.
- R5: Descriptors leave in segment order and address order. A new segment is accepted only after the current one is used up, and a zero-length segment produces no descriptor.
- R6: `done` is high for exactly one cycle per request, after the segment flagged by `seg_last` is taken. `desc_total` then gives the number of descriptors generated for the request. In a normal finish, `done` rises in the same cycle that the final descriptor is first presented.
- R7: A request whose segments carry no bytes produces no descriptor and finishes with `empty`=1, `overflow`=0 and `desc_total`=0.
- R8: If a request needs more than `MAX_DESC` descriptors, it finishes with `overflow`=1 and `desc_total`=`MAX_DESC`. Only the first `MAX_DESC`-1 descriptors are delivered, none carries an end mark, and segments are still accepted and dropped up to the one flagged last.
- R9: While `desc_valid` is high and `desc_ready` is low, `desc_valid`, `desc_addr` and `desc_word` hold their values.
- R10: After reset, `desc_valid` and `done` are 0 and `seg_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| quad_mode | input | 1 | 1 selects the word-unit count encoding; hold stable during a request |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment taken on this edge when valid |
| seg_addr | input | AW (32) | Segment start address |
| seg_len | input | LW (32) | Segment length in bytes |
| seg_last | input | 1 | Segment closes the request |
| desc_valid | output | 1 | Descriptor presented |
| desc_ready | input | 1 | Consumer takes the descriptor |
| desc_addr | output | AW (32) | Descriptor address word |
| desc_word | output | 32 | Descriptor count/flag word |
| done | output | 1 | One-cycle request-finished pulse |
| desc_total | output | $clog2(MAX_DESC+1) | Descriptors generated for the request, valid with done |
| overflow | output | 1 | Request exceeded MAX_DESC, valid with done |
| empty | output | 1 | Request produced no descriptor, valid with done |

## Verification
A taken segment produces its first chunk in the holding register one edge later. That chunk reaches `desc_valid` only when the next chunk is generated or the request closes. The closing descriptor and `done` appear together on the same edge, two edges after the last bytes are cut. `desc_ready` is randomised, so the bench does not count absolute cycles. Instead it samples every falling edge, logs a transfer whenever valid and ready are both high there, and compares the logged descriptors in order against a model computed by a bench function. It reads `desc_total`, `overflow` and `empty` at the falling edge where `done` is seen, and checks that a held descriptor is unchanged at the next falling edge.

// File: rtl/span_pkg.sv
package span_pkg;

  typedef enum logic [1:0] {
    ST_TAKE  = 2'd0,
    ST_CUT   = 2'd1,
    ST_CLOSE = 2'd2,
    ST_SKIP  = 2'd3
  } span_st_e;

  localparam int BOUND_W = 16;
  localparam int CHUNK_W = BOUND_W + 1;
  localparam int WORD_W  = 32;

endpackage

// File: rtl/span_chunk_calc.sv
module span_chunk_calc
  import span_pkg::*;
#(
  parameter int LW = 32
) (
  input  logic [BOUND_W-1:0] addr_lo,
  input  logic [LW-1:0]      rem,
  input  logic               halve_full,
  output logic [CHUNK_W-1:0] bytes
);
  logic [CHUNK_W-1:0] room;
  logic [CHUNK_W-1:0] take;

  always_comb begin
    room = {1'b1, {BOUND_W{1'b0}}} - {1'b0, addr_lo};
    take = (rem < LW'(room)) ? rem[CHUNK_W-1:0] : room;
    if (halve_full && take[BOUND_W])
      bytes = {2'b01, {(BOUND_W-1){1'b0}}};
    else
      bytes = take;
  end
endmodule

// File: rtl/span_word_enc.sv
module span_word_enc
  import span_pkg::*;
(
  input  logic [CHUNK_W-1:0] bytes,
  input  logic               quad,
  input  logic               final_d,
  output logic [WORD_W-1:0]  word
);
  logic [BOUND_W-1:0] quarters;

  always_comb begin
    quarters = {1'b0, bytes[CHUNK_W-1:2]} - 16'd1;
    if (quad)
      word = {quarters, {BOUND_W{1'b0}}};
    else
      word = {final_d, {(WORD_W-BOUND_W-1){1'b0}}, bytes[BOUND_W-1:0]};
  end
endmodule

// File: rtl/span_splitter.sv
module span_splitter
  import span_pkg::*;
#(
  parameter int MAX_DESC = 256,
  parameter int AW       = 32,
  parameter int LW       = 32,
  localparam int CW      = $clog2(MAX_DESC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          quad_mode,
  input  logic          seg_valid,
  output logic          seg_ready,
  input  logic [AW-1:0] seg_addr,
  input  logic [LW-1:0] seg_len,
  input  logic          seg_last,
  output logic          desc_valid,
  input  logic          desc_ready,
  output logic [AW-1:0] desc_addr,
  output logic [31:0]   desc_word,
  output logic          done,
  output logic [CW-1:0] desc_total,
  output logic          overflow,
  output logic          empty
);
  localparam logic [CW-1:0] CAP = CW'(MAX_DESC);

  span_st_e st;

  logic [AW-1:0]      cur_addr;
  logic [LW-1:0]      cur_rem;
  logic               cur_last;
  logic               pend_v;
  logic [AW-1:0]      pend_addr;
  logic [CHUNK_W-1:0] pend_bytes;
  logic               out_v;
  logic [AW-1:0]      out_addr;
  logic [WORD_W-1:0]  out_word;
  logic [CW-1:0]      cnt;
  logic               done_r, ovf_r, empty_r;
  logic [CW-1:0]      total_r;

  logic [CHUNK_W-1:0] chunk;
  logic [WORD_W-1:0]  enc_word;
  logic               out_free;

  assign out_free = !out_v || desc_ready;

  span_chunk_calc #(.LW(LW)) u_calc (
    .addr_lo    (cur_addr[BOUND_W-1:0]),
    .rem        (cur_rem),
    .halve_full (!quad_mode),
    .bytes      (chunk)
  );

  span_word_enc u_enc (
    .bytes   (pend_bytes),
    .quad    (quad_mode),
    .final_d (st == ST_CLOSE),
    .word    (enc_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_TAKE;
      cur_addr   <= '0;
      cur_rem    <= '0;
      cur_last   <= 1'b0;
      pend_v     <= 1'b0;
      pend_addr  <= '0;
      pend_bytes <= '0;
      out_v      <= 1'b0;
      out_addr   <= '0;
      out_word   <= '0;
      cnt        <= '0;
      done_r     <= 1'b0;
      ovf_r      <= 1'b0;
      empty_r    <= 1'b0;
      total_r    <= '0;
    end else begin
      done_r <= 1'b0;
      if (out_v && desc_ready) out_v <= 1'b0;
      case (st)
        ST_TAKE: begin
          if (seg_valid) begin
            cur_addr <= seg_addr;
            cur_rem  <= seg_len;
            cur_last <= seg_last;
            st       <= ST_CUT;
          end
        end
        ST_CUT: begin
          if (cur_rem == '0) begin
            st <= cur_last ? ST_CLOSE : ST_TAKE;
          end else if (!pend_v || out_free) begin
            if (cnt == CAP) begin
              pend_v <= 1'b0;
              if (cur_last) begin
                done_r  <= 1'b1;
                ovf_r   <= 1'b1;
                empty_r <= 1'b0;
                total_r <= cnt;
                cnt     <= '0;
                st      <= ST_TAKE;
              end else begin
                st <= ST_SKIP;
              end
            end else begin
              if (pend_v) begin
                out_v    <= 1'b1;
                out_addr <= pend_addr;
                out_word <= enc_word;
              end
              pend_v     <= 1'b1;
              pend_addr  <= cur_addr;
              pend_bytes <= chunk;
              cur_addr   <= cur_addr + AW'(chunk);
              cur_rem    <= cur_rem - LW'(chunk);
              cnt        <= cnt + 1'b1;
            end
          end
        end
        ST_CLOSE: begin
          if (!pend_v) begin
            done_r  <= 1'b1;
            empty_r <= 1'b1;
            ovf_r   <= 1'b0;
            total_r <= '0;
            cnt     <= '0;
            st      <= ST_TAKE;
          end else if (out_free) begin
            out_v    <= 1'b1;
            out_addr <= pend_addr;
            out_word <= enc_word;
            pend_v   <= 1'b0;
            done_r   <= 1'b1;
            empty_r  <= 1'b0;
            ovf_r    <= 1'b0;
            total_r  <= cnt;
            cnt      <= '0;
            st       <= ST_TAKE;
          end
        end
        default: begin
          if (seg_valid && seg_last) begin
            done_r  <= 1'b1;
            ovf_r   <= 1'b1;
            empty_r <= 1'b0;
            total_r <= cnt;
            cnt     <= '0;
            st      <= ST_TAKE;
          end
        end
      endcase
    end
  end

  assign seg_ready  = (st == ST_TAKE) || (st == ST_SKIP);
  assign desc_valid = out_v;
  assign desc_addr  = out_addr;
  assign desc_word  = out_word;
  assign done       = done_r;
  assign desc_total = total_r;
  assign overflow   = ovf_r;
  assign empty      = empty_r;
endmodule

module span_splitter_chk #(
  parameter int MAX_DESC = 256,
  parameter int AW       = 32,
  localparam int CW      = $clog2(MAX_DESC + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          quad_mode,
  input logic          seg_valid,
  input logic          seg_ready,
  input logic          seg_last,
  input logic          desc_valid,
  input logic          desc_ready,
  input logic [AW-1:0] desc_addr,
  input logic [31:0]   desc_word,
  input logic          done,
  input logic [CW-1:0] desc_total,
  input logic          overflow,
  input logic          empty
);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_addr) && $stable(desc_word));

  // R1
  no_cross_chk: assert property (@(posedge clk) disable iff (rst)
    desc_valid && !quad_mode |->
      (desc_word[15:0] != 16'h0) &&
      (({1'b0, desc_addr[15:0]} + {1'b0, desc_word[15:0]}) <= 17'h10000));

  // R3
  end_mark_chk: assert property (@(posedge clk) disable iff (rst)
    done && !overflow && !empty && !quad_mode |-> desc_valid && desc_word[31]);

  // R4
  quad_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    desc_valid && quad_mode |-> desc_word[15:0] == 16'h0);

  // R7
  empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done && empty |-> desc_total == '0 && !overflow);

  // R8
  ovf_total_chk: assert property (@(posedge clk) disable iff (rst)
    done && overflow |-> desc_total == CW'(MAX_DESC));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  mid_req_chk: assert property (@(posedge clk) disable iff (rst)
    seg_valid && seg_ready && !seg_last |=> !done);
endmodule

bind span_splitter span_splitter_chk #(.MAX_DESC(MAX_DESC), .AW(AW)) u_chk (.*);

// File: tb/span_splitter_test.sv
`timescale 1ns/1ps
module span_splitter_test;
  localparam int MAXD = 12;
  localparam int CW   = $clog2(MAXD + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic quad_mode = 1'b0;
  logic seg_valid = 1'b0;
  logic seg_ready;
  logic [31:0] seg_addr = '0;
  logic [31:0] seg_len = '0;
  logic seg_last = 1'b0;
  logic desc_valid;
  logic desc_ready = 1'b0;
  logic [31:0] desc_addr;
  logic [31:0] desc_word;
  logic done;
  logic [CW-1:0] desc_total;
  logic overflow;
  logic empty;

  always #2.5 clk = ~clk;

  span_splitter #(.MAX_DESC(MAXD)) uut (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit rdy_always = 1'b0;

  logic [31:0] seg_a [16];
  logic [31:0] seg_l [16];
  logic [31:0] exp_a [64];
  logic [31:0] exp_w [64];
  int exp_total, exp_dlv;
  bit exp_ovf, exp_empty;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic build_expect(input int nseg, input bit qm);
    int cnt = 0;
    logic [31:0] b [64];
    exp_ovf = 1'b0;
    for (int i = 0; i < nseg; i++) begin
      logic [31:0] a = seg_a[i];
      logic [31:0] r = seg_l[i];
      while (r != 0 && !exp_ovf) begin
        logic [31:0] room = 32'h10000 - {16'h0, a[15:0]};
        logic [31:0] c = (r < room) ? r : room;
        if (!qm && c == 32'h10000) c = 32'h8000;
        if (cnt == MAXD) exp_ovf = 1'b1;
        else begin
          exp_a[cnt] = a; b[cnt] = c; cnt++; a += c; r -= c;
        end
      end
    end
    exp_total = cnt;
    exp_empty = (cnt == 0);
    exp_dlv = exp_ovf ? cnt - 1 : cnt;
    for (int k = 0; k < cnt; k++) begin
      if (qm) begin
        logic [15:0] q = b[k][17:2] - 16'd1;
        exp_w[k] = {q, 16'h0};
      end else
        exp_w[k] = {(k == cnt - 1) && !exp_ovf, 15'h0, b[k][15:0]};
    end
  endtask

  task automatic drive_segs(input int nseg);
    for (int i = 0; i < nseg; i++) begin
      seg_valid = 1'b1;
      seg_addr = seg_a[i];
      seg_len = seg_l[i];
      seg_last = (i == nseg - 1);
      while (!seg_ready) @(negedge clk);
      @(negedge clk);
      seg_valid = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
    end
  endtask

  task automatic collect();
    int got = 0;
    bit seen_done = 1'b0;
    bit hold = 1'b0;
    logic [31:0] ha, hw;
    forever begin
      @(negedge clk);
      if (hold) begin
        // R9 held descriptor unchanged
        chk(desc_valid && desc_addr == ha && desc_word == hw, "R9", "held descriptor",
            {desc_addr, desc_word}, {ha, hw});
        hold = 1'b0;
      end
      if (done) begin
        seen_done = 1'b1;
        // R6 R7 R8 request status
        chk(desc_total == CW'(exp_total), "R6", "desc_total", 64'(desc_total), 64'(exp_total));
        chk(overflow == exp_ovf, "R8", "overflow", 64'(overflow), 64'(exp_ovf));
        chk(empty == exp_empty, "R7", "empty", 64'(empty), 64'(exp_empty));
        if (!exp_ovf && !exp_empty)
          chk(desc_valid && desc_addr == exp_a[exp_total-1], "R6", "final presented with done",
              {31'h0, desc_valid, desc_addr}, {32'h1, exp_a[exp_total-1]});
      end
      if (seen_done && !desc_valid) break;
      desc_ready = rdy_always ? 1'b1 : (($urandom % 4) != 0);
      if (desc_valid && desc_ready) begin
        if (got < exp_dlv) begin
          // R1 R2 R3 R4 R5 descriptor content and order
          chk(desc_addr == exp_a[got], "R1", "desc address", 64'(desc_addr), 64'(exp_a[got]));
          chk(desc_word == exp_w[got], quad_mode ? "R4" : "R3", "desc word",
              64'(desc_word), 64'(exp_w[got]));
        end else
          chk(1'b0, "R5", "extra descriptor", 64'(got), 64'(exp_dlv));
        got++;
      end else if (desc_valid) begin
        hold = 1'b1; ha = desc_addr; hw = desc_word;
      end
    end
    // R5 R8 delivered count
    chk(got == exp_dlv, "R5", "descriptors delivered", 64'(got), 64'(exp_dlv));
  endtask

  task automatic run_req(input int nseg, input bit qm);
    quad_mode = qm;
    build_expect(nseg, qm);
    fork
      drive_segs(nseg);
      collect();
    join
    desc_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!desc_valid, "R10", "desc_valid after reset", 64'(desc_valid), 64'h0);
    chk(!done, "R10", "done after reset", 64'(done), 64'h0);
    chk(seg_ready, "R10", "seg_ready after reset", 64'(seg_ready), 64'h1);

    // R1 small single and boundary crossing
    seg_a[0] = 32'h0000_1000; seg_l[0] = 32'h200; run_req(1, 1'b0);
    seg_a[0] = 32'h0001_FFF0; seg_l[0] = 32'h30;  run_req(1, 1'b0);
    // R2 aligned and unaligned 64 KB chunks
    seg_a[0] = 32'h0002_0000; seg_l[0] = 32'h10000; run_req(1, 1'b0);
    seg_a[0] = 32'h0003_8000; seg_l[0] = 32'h10000; run_req(1, 1'b0);
    // R3 R5 zero-length trailing segment keeps end mark on real final
    seg_a[0] = 32'h100; seg_l[0] = 32'h40; seg_a[1] = 32'h500; seg_l[1] = 32'h0;
    run_req(2, 1'b0);
    // R7 empty request
    seg_a[0] = 32'h700; seg_l[0] = 32'h0; seg_a[1] = 32'h900; seg_l[1] = 32'h0;
    run_req(2, 1'b0);
    // R4 word-unit encoding
    seg_a[0] = 32'h0; seg_l[0] = 32'h10000; seg_a[1] = 32'h0004_FFF8; seg_l[1] = 32'h10;
    run_req(2, 1'b1);
    // R8 overflow with segments to drain
    seg_a[0] = 32'h0; seg_l[0] = 32'h100000; seg_a[1] = 32'h5000; seg_l[1] = 32'h100;
    seg_a[2] = 32'h9000; seg_l[2] = 32'h40;
    run_req(3, 1'b0);
    // R8 exactly at the limit is not overflow
    for (int i = 0; i < 6; i++) begin seg_a[i] = 32'h0010_0000 * i; seg_l[i] = 32'h10000; end
    rdy_always = 1'b1;
    run_req(6, 1'b0);
    rdy_always = 1'b0;

    for (int t = 0; t < 60; t++) begin
      int ns = 1 + ($urandom % 4);
      bit qm = ($urandom % 3) == 0;
      rdy_always = ($urandom % 4) == 0;
      for (int i = 0; i < ns; i++) begin
        int kind = $urandom % 6;
        seg_a[i] = $urandom;
        seg_l[i] = (kind == 0) ? 32'h0 : (kind == 1) ? 32'h10000 : ($urandom % 32'h18000);
        if (kind == 2) seg_a[i][15:0] = 16'h0;
        if (qm) begin seg_a[i][1:0] = 2'b00; seg_l[i][1:0] = 2'b00; end
      end
      run_req(ns, qm);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule